// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing-generator chip up, re-programs it on a mode change, and takes it down again. It does this by issuing single-cycle register writes (3-bit address, 8-bit data) on a write-only port. Between some writes it waits a fixed number of milliseconds. At two points in each long sequence it programs the panel's common-voltage bias DAC. It does so by handing a base byte and a level byte to an external serial bit-bang engine through a start/busy handshake, and it waits for that engine to finish before moving on.

A request is sampled only while the block is idle. On an accepted request the block latches the mode select and the stored phase and bias values. An internal "panel ready" flag selects between two init sequences. When the flag is clear, an init request runs the full power-up sequence. When the flag is set, an init request rewrites only the phase and resolution registers. A suspend request waits two frame times, unwinds the supplies in reverse order and clears the flag. Every sequence ends with a one-cycle done pulse. Delays are counted in units of `CLK_KHZ` clock cycles, so a fast clock parameter gives real milliseconds and a small one gives short benches.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `reg_wr`, `dac_start` and `done` are low and `panel_ready` is 0, and no write occurs until a request is accepted.
- R2: An init request with `panel_ready`=0 produces exactly this sequence of (address, data) writes, shown in hex, where DAC marks a bias-DAC call: (6,1F) (3,03) (4,00) (4,04) (3,07) (6,09) DAC (3,17) (4,06) (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00) (0,res). The first write comes in the cycle after the request is sampled, and writes with no delay or DAC call between them come on consecutive cycles.
- R3: A wait of N ms lasts N*`CLK_KHZ` cycles. The write that follows it comes N*`CLK_KHZ`+2 cycles after the write that precedes it. Full init waits 3 ms after (4,04), 2 ms after (4,06), and 1 ms after (7,00).
- R4: A bias-DAC call pulses `dac_start` for one cycle with `dac_base` and `dac_level` valid. The engine raises `dac_busy` at the clock edge that samples `dac_start`. The next write comes in the second cycle after `dac_busy` is seen low. In full init the call uses base 0x04 and level `comv_val` when `comv_vld`=1, otherwise 125 (0x7D).
- R5: The phase byte (address 1) in VGA mode (`mode_vga`=1) is {3'b0, `phase_trim`, 1'b1} when `phase_vld`=1, otherwise 0x01. In QVGA mode it is 0x13, and the stored phase is ignored.
- R6: The last write of every init sequence goes to address 0 with data 0x00 in VGA mode and 0x01 in QVGA mode.
- R7: An init request with `panel_ready`=1 writes only (1,phase) and then (0,res), on consecutive cycles starting the cycle after the request.
- R8: A suspend request waits 34 ms and then writes (4,06) (6,08) (3,14) DAC (4,04) (3,04) (6,1E) (3,00) (4,00). The DAC call uses base 0x14 and level 0x00. The first write comes 34*`CLK_KHZ`+2 cycles after the request is sampled. At the end `panel_ready` returns to 0.
- R9: Requests that arrive while a sequence runs are ignored. If both requests arrive together while idle, the init request is accepted.
- R10: `done` is high for exactly one cycle, in the cycle after the last write of a sequence. `panel_ready` changes only at the end of a sequence: it is set by an init and cleared by a suspend.
- R11: Every write is a one-cycle `reg_wr` strobe to one of the addresses 0, 1, 3, 4, 6 or 7, and `reg_wr` and `dac_start` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Initialise or resume request, sampled while idle |
| susp_req | input | 1 | Suspend request, sampled while idle |
| mode_vga | input | 1 | 1 selects VGA resolution, 0 selects QVGA |
| phase_trim | input | 4 | Stored phase adjustment |
| phase_vld | input | 1 | `phase_trim` holds a valid stored value |
| comv_val | input | 8 | Stored common-voltage level |
| comv_vld | input | 1 | `comv_val` holds a valid stored value |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 3 | Register address |
| reg_data | output | 8 | Register data |
| dac_start | output | 1 | Start pulse to the bias-DAC bit-bang engine |
| dac_base | output | 8 | Power-register base value for the engine |
| dac_level | output | 8 | Level to load into the bias DAC |
| dac_busy | input | 1 | Engine is shifting |
| done | output | 1 | One-cycle end-of-sequence pulse |
| panel_ready | output | 1 | Panel has been initialised and not suspended |

## Verification
The bench checks the boundaries of every wait to the exact cycle. A timer that is off by one, or that counts the wrong unit, shifts the write after a 1, 2, 3 or 34 ms wait. It also checks the cycle in which the sequence resumes after the DAC engine drops busy, which catches a design that ignores busy or overlaps a write with the shift. A request placed inside a running wait would append a second sequence or restart the first if it were not ignored. Back-to-back init requests check that the ready flag shortens the second one to two writes. Simultaneous requests check the stated priority. The QVGA run checks that stored phase is ignored there while stored bias is still used.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int MS_W   = 6;
    localparam int STEP_W = 5;

    // register map of the timing generator
    localparam logic [ADDR_W-1:0] A_RES   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PHASE = 3'd1;
    localparam logic [ADDR_W-1:0] A_PWR0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PWR1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PANEL = 3'd6;
    localparam logic [ADDR_W-1:0] A_POL   = 3'd7;

    // program entry points
    localparam logic [STEP_W-1:0] P_FULL  = 5'd0;
    localparam logic [STEP_W-1:0] P_PHASE = 5'd15;
    localparam logic [STEP_W-1:0] P_RES   = 5'd18;
    localparam logic [STEP_W-1:0] P_SUSP  = 5'd20;

    localparam logic [DATA_W-1:0] COMV_DEFAULT = 8'd125;
    localparam logic [DATA_W-1:0] PHASE_QVGA   = 8'h13;

    typedef enum logic [1:0] {OP_WR, OP_WAIT, OP_DAC, OP_END} op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } step_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DAC, S_HOLD} st_e;

    typedef struct packed {
        st_e               st;
        logic [STEP_W-1:0] step;
        logic              brief;
        logic              ready;
        logic [DATA_W-1:0] ph;
        logic [DATA_W-1:0] res;
        logic [DATA_W-1:0] comv;
    } ctl_t;

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int CLK_KHZ = 125000,
    parameter int MS_W    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms,
    output logic            expire
);
    localparam int CNT_W = $clog2(CLK_KHZ + 1);
    localparam logic [CNT_W-1:0] CYC_TOP = CNT_W'(CLK_KHZ - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cyc;
        logic [MS_W-1:0]  left;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        expire = q.busy && (q.cyc == '0) && (q.left == '0);
        if (start) begin
            d.busy = 1'b1;
            d.cyc  = CYC_TOP;
            d.left = ms - 1'b1;
        end else if (q.busy) begin
            if (q.cyc != '0) begin
                d.cyc = q.cyc - 1'b1;
            end else if (q.left == '0) begin
                d.busy = 1'b0;
            end else begin
                d.left = q.left - 1'b1;
                d.cyc  = CYC_TOP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lcd_seq_prog.sv
module lcd_seq_prog
    import lcd_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] ph,
    input  logic [DATA_W-1:0] res,
    input  logic [DATA_W-1:0] comv,
    output step_t             cur,
    output logic [DATA_W-1:0] dac_base
);
    function automatic step_t mk(op_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v);
        step_t s;
        s.op   = op;
        s.addr = a;
        s.data = v;
        return s;
    endfunction

    always_comb begin
        dac_base = 8'h00;
        case (step)
            // power-up
            5'd0:  cur = mk(OP_WR,   A_PANEL, 8'h1F);
            5'd1:  cur = mk(OP_WR,   A_PWR0,  8'h03);
            5'd2:  cur = mk(OP_WR,   A_PWR1,  8'h00);
            5'd3:  cur = mk(OP_WR,   A_PWR1,  8'h04);
            5'd4:  cur = mk(OP_WAIT, 3'd0,    8'd3);
            5'd5:  cur = mk(OP_WR,   A_PWR0,  8'h07);
            5'd6:  cur = mk(OP_WR,   A_PANEL, 8'h09);
            5'd7:  begin cur = mk(OP_DAC, 3'd0, comv); dac_base = 8'h04; end
            5'd8:  cur = mk(OP_WR,   A_PWR0,  8'h17);
            5'd9:  cur = mk(OP_WR,   A_PWR1,  8'h06);
            5'd10: cur = mk(OP_WAIT, 3'd0,    8'd2);
            5'd11: cur = mk(OP_WR,   A_PANEL, 8'h01);
            5'd12: cur = mk(OP_WR,   A_PWR0,  8'h1F);
            5'd13: cur = mk(OP_WR,   A_PWR1,  8'h07);
            5'd14: cur = mk(OP_WR,   A_PANEL, 8'h00);
            5'd15: cur = mk(OP_WR,   A_PHASE, ph);
            5'd16: cur = mk(OP_WR,   A_POL,   8'h00);
            5'd17: cur = mk(OP_WAIT, 3'd0,    8'd1);
            5'd18: cur = mk(OP_WR,   A_RES,   res);
            5'd19: cur = mk(OP_END,  3'd0,    8'h00);
            // power-down
            5'd20: cur = mk(OP_WAIT, 3'd0,    8'd34);
            5'd21: cur = mk(OP_WR,   A_PWR1,  8'h06);
            5'd22: cur = mk(OP_WR,   A_PANEL, 8'h08);
            5'd23: cur = mk(OP_WR,   A_PWR0,  8'h14);
            5'd24: begin cur = mk(OP_DAC, 3'd0, 8'h00); dac_base = 8'h14; end
            5'd25: cur = mk(OP_WR,   A_PWR1,  8'h04);
            5'd26: cur = mk(OP_WR,   A_PWR0,  8'h04);
            5'd27: cur = mk(OP_WR,   A_PANEL, 8'h1E);
            5'd28: cur = mk(OP_WR,   A_PWR0,  8'h00);
            5'd29: cur = mk(OP_WR,   A_PWR1,  8'h00);
            default: cur = mk(OP_END, 3'd0,   8'h00);
        endcase
    end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_KHZ = 125000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              susp_req,
    input  logic              mode_vga,
    input  logic [3:0]        phase_trim,
    input  logic              phase_vld,
    input  logic [DATA_W-1:0] comv_val,
    input  logic              comv_vld,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_data,
    output logic              dac_start,
    output logic [DATA_W-1:0] dac_base,
    output logic [DATA_W-1:0] dac_level,
    input  logic              dac_busy,
    output logic              done,
    output logic              panel_ready
);
    ctl_t  q, d;
    step_t cur;
    logic  tmr_start, tmr_expire;

    lcd_seq_prog u_prog (
        .step     (q.step),
        .ph       (q.ph),
        .res      (q.res),
        .comv     (q.comv),
        .cur      (cur),
        .dac_base (dac_base)
    );

    lcd_seq_timer #(.CLK_KHZ(CLK_KHZ), .MS_W(MS_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .ms     (cur.data[MS_W-1:0]),
        .expire (tmr_expire)
    );

    always_comb begin
        d         = q;
        reg_wr    = 1'b0;
        dac_start = 1'b0;
        tmr_start = 1'b0;
        done      = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (init_req) begin
                    d.st    = S_RUN;
                    d.brief = q.ready;
                    d.step  = q.ready ? P_PHASE : P_FULL;
                    d.res   = mode_vga ? 8'h00 : 8'h01;
                    d.comv  = comv_vld ? comv_val : COMV_DEFAULT;
                    if (!mode_vga)      d.ph = PHASE_QVGA;
                    else if (phase_vld) d.ph = {3'b000, phase_trim, 1'b1};
                    else                d.ph = 8'h01;
                end else if (susp_req) begin
                    d.st    = S_RUN;
                    d.brief = 1'b0;
                    d.step  = P_SUSP;
                end
            end
            S_RUN: begin
                case (cur.op)
                    OP_WR: begin
                        reg_wr = 1'b1;
                        d.step = (q.brief && q.step == P_PHASE) ? P_RES : q.step + 1'b1;
                    end
                    OP_WAIT: begin
                        tmr_start = 1'b1;
                        d.st      = S_HOLD;
                    end
                    OP_DAC: begin
                        dac_start = 1'b1;
                        d.st      = S_DAC;
                    end
                    default: begin
                        done    = 1'b1;
                        d.st    = S_IDLE;
                        d.ready = (q.step < P_SUSP);
                    end
                endcase
            end
            S_HOLD: begin
                if (tmr_expire) begin
                    d.st   = S_RUN;
                    d.step = q.step + 1'b1;
                end
            end
            default: begin
                if (!dac_busy) begin
                    d.st   = S_RUN;
                    d.step = q.step + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reg_addr    = cur.addr;
    assign reg_data    = cur.data;
    assign dac_level   = cur.data;
    assign panel_ready = q.ready;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk
    import lcd_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_data,
    input logic              dac_start,
    input logic              dac_busy,
    input logic              done,
    input logic              panel_ready
);
    // R11: a write strobe and a DAC start never share a cycle
    a_r11_excl_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && dac_start));

    // R11: only mapped registers are written
    a_r11_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (reg_addr != 3'd2 && reg_addr != 3'd5));

    // R10: done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: ready flag moves only at the end of a sequence
    a_r10_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_ready) |-> $past(done));
    a_r10_ready_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_ready) |-> $past(done));

    // R4: nothing is written while the DAC engine shifts
    a_r4_quiet_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dac_busy |-> !reg_wr);

    // R5: the phase byte always carries the manual-phase bit
    a_r5_phase_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |-> reg_data[0]);
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_data    (reg_data),
    .dac_start   (dac_start),
    .dac_busy    (dac_busy),
    .done        (done),
    .panel_ready (panel_ready)
);

// File: tb/tb_lcd_pwr_seq.sv
module tb_lcd_pwr_seq;
    localparam int K = 20;
    localparam logic [7:0] DACM = 8'hF0;

    logic clk = 1'b0, rst_n = 1'b0;
    logic init_req = 0, susp_req = 0, mode_vga = 1, phase_vld = 0, comv_vld = 0;
    logic [3:0] phase_trim = 4'h0;
    logic [7:0] comv_val = 8'h00;
    logic reg_wr, dac_start, done, panel_ready, dac_busy;
    logic [2:0] reg_addr;
    logic [7:0] reg_data, dac_base, dac_level;

    int checks = 0, fails = 0, cyc = 0, req_cyc = 0;
    int log_n = 0, done_n = 0, done_cyc = 0;
    logic [7:0] log_a [64];
    logic [7:0] log_d [64];
    logic [7:0] log_b [64];
    int         log_t [64];
    int         bcnt = 0;

    // {gap from previous entry (first: from request), addr, data}; placeholders for phase/res/DAC level
    localparam logic [31:0] VEC [25] = '{
        {16'd1, 8'h06, 8'h1F}, {16'd1, 8'h03, 8'h03}, {16'd1, 8'h04, 8'h00},
        {16'd1, 8'h04, 8'h04}, {16'(3*K+2), 8'h03, 8'h07}, {16'd1, 8'h06, 8'h09},
        {16'd1, DACM, 8'h00}, {16'd7, 8'h03, 8'h17}, {16'd1, 8'h04, 8'h06},
        {16'(2*K+2), 8'h06, 8'h01}, {16'd1, 8'h03, 8'h1F}, {16'd1, 8'h04, 8'h07},
        {16'd1, 8'h06, 8'h00}, {16'd1, 8'h01, 8'h00}, {16'd1, 8'h07, 8'h00},
        {16'(K+2), 8'h00, 8'h00},
        {16'(34*K+2), 8'h04, 8'h06}, {16'd1, 8'h06, 8'h08}, {16'd1, 8'h03, 8'h14},
        {16'd1, DACM, 8'h00}, {16'd7, 8'h04, 8'h04}, {16'd1, 8'h03, 8'h04},
        {16'd1, 8'h06, 8'h1E}, {16'd1, 8'h03, 8'h00}, {16'd1, 8'h04, 8'h00}
    };

    lcd_pwr_seq #(.CLK_KHZ(K)) dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .susp_req(susp_req),
        .mode_vga(mode_vga), .phase_trim(phase_trim), .phase_vld(phase_vld),
        .comv_val(comv_val), .comv_vld(comv_vld), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_data(reg_data), .dac_start(dac_start),
        .dac_base(dac_base), .dac_level(dac_level), .dac_busy(dac_busy),
        .done(done), .panel_ready(panel_ready)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // bit-bang engine model: busy from the sampling edge for five cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_busy <= 1'b0;
            bcnt     <= 0;
        end else if (dac_start) begin
            dac_busy <= 1'b1;
            bcnt     <= 4;
        end else if (dac_busy) begin
            if (bcnt == 0) dac_busy <= 1'b0;
            else           bcnt <= bcnt - 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && log_n < 64 && (reg_wr || dac_start)) begin
            log_a[log_n] = reg_wr ? {5'd0, reg_addr} : DACM;
            log_d[log_n] = reg_wr ? reg_data : dac_level;
            log_b[log_n] = dac_base;
            log_t[log_n] = cyc;
            log_n = log_n + 1;
        end
        if (rst_n && done) begin
            done_n   = done_n + 1;
            done_cyc = cyc;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic req(input logic i, input logic s);
        @(negedge clk);
        log_n = 0; done_n = 0;
        init_req = i; susp_req = s; req_cyc = cyc;
        @(negedge clk);
        init_req = 0; susp_req = 0;
    endtask

    task automatic settle();
        for (int i = 0; i < 3000 && done_n == 0; i++) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    // walk a slice of the vector table
    task automatic walk(input int base, input int n, input logic [7:0] ph,
                        input logic [7:0] res, input logic [7:0] lvl, input logic [7:0] bse);
        chk(log_n == n, "R2/R8 write count", log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            logic [7:0] ea, ed;
            int eg, ag;
            ea = VEC[base+i][15:8];
            ed = VEC[base+i][7:0];
            eg = int'(VEC[base+i][31:16]);
            if (ea == DACM) ed = lvl;
            if (ea == 8'h01) ed = ph;
            if (ea == 8'h00) ed = res;
            ag = (i == 0) ? log_t[0] - req_cyc : log_t[i] - log_t[i-1];
            chk(log_a[i] == ea, "R2/R8 address order", log_a[i], ea);
            chk(log_d[i] == ed, "R2/R5/R6/R8 data", log_d[i], ed);
            chk(ag == eg, "R3/R4 cycle gap", ag, eg);
            if (ea == DACM) chk(log_b[i] == bse, "R4/R8 DAC base", log_b[i], bse);
        end
        chk(done_n == 1, "R10 one done pulse", done_n, 1);
        if (log_n > 0) chk(done_cyc == log_t[log_n-1] + 1, "R10 done timing", done_cyc, log_t[log_n-1] + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!reg_wr && !dac_start && !done, "R1 strobes idle in reset", {reg_wr, dac_start, done}, 0);
        chk(panel_ready == 1'b0, "R1 ready clear", panel_ready, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(log_n == 0 && !panel_ready, "R1 no writes after reset", log_n, 0);

        // R2 R3 R4 full init VGA without stored values; R9 suspend inside the wait is ignored
        req(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        susp_req = 1'b1; init_req = 1'b1;
        @(negedge clk);
        susp_req = 1'b0; init_req = 1'b0;
        settle();
        walk(0, 16, 8'h01, 8'h00, 8'h7D, 8'h04);
        chk(panel_ready == 1'b1, "R10 ready set after init", panel_ready, 1);

        // R7 R5 re-init in QVGA: phase and resolution only
        mode_vga = 1'b0; phase_vld = 1'b1; phase_trim = 4'hA;
        req(1'b1, 1'b0); settle();
        chk(log_n == 2, "R7 short init count", log_n, 2);
        chk(log_a[0] == 8'h01 && log_d[0] == 8'h13, "R5 QVGA phase", {log_a[0], log_d[0]}, 16'h0113);
        chk(log_a[1] == 8'h00 && log_d[1] == 8'h01, "R6 QVGA resolution", {log_a[1], log_d[1]}, 16'h0001);
        chk(log_t[0] == req_cyc + 1 && log_t[1] == req_cyc + 2, "R7 short timing", log_t[1] - req_cyc, 2);

        // R5 VGA with stored phase 0x7 -> 0x0F
        mode_vga = 1'b1; phase_trim = 4'h7;
        req(1'b1, 1'b0); settle();
        chk(log_n == 2 && log_d[0] == 8'h0F, "R5 VGA stored phase", log_d[0], 8'h0F);
        chk(log_d[1] == 8'h00, "R6 VGA resolution", log_d[1], 0);

        // R9 simultaneous requests: init wins
        phase_vld = 1'b0;
        req(1'b1, 1'b1); settle();
        chk(log_n == 2 && log_a[0] == 8'h01 && log_d[0] == 8'h01, "R9 init priority", log_n, 2);
        chk(panel_ready == 1'b1, "R9 ready kept", panel_ready, 1);

        // R8 suspend
        req(1'b0, 1'b1); settle();
        walk(16, 9, 8'h00, 8'h00, 8'h00, 8'h14);
        chk(panel_ready == 1'b0, "R8 ready cleared", panel_ready, 0);

        // R2 R4 R5 R6 full init in QVGA with stored bias and ignored stored phase
        mode_vga = 1'b0; comv_vld = 1'b1; comv_val = 8'h55; phase_vld = 1'b1; phase_trim = 4'h3;
        req(1'b1, 1'b0); settle();
        walk(0, 16, 8'h13, 8'h01, 8'h55, 8'h04);
        chk(panel_ready == 1'b1, "R10 ready after second full init", panel_ready, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule